// File: doc/BRIEF.md
# Combined External Interrupt Request Latch

This block merges one dedicated interrupt pin, which is active low, with a group of active-high port pins into a single latched interrupt request for a CPU core. Every pin passes through a multi-flop synchronizer. The synchronized dedicated pin is inverted so that it is active high. It is then ORed with the port group into one combined line. The port group joins that line only when a fixed option input selects it and a run-time enable bit is set. A rising transition of the combined line sets the request latch. In the edge-and-level trigger mode, an active level also sets it, so a wired-OR source that stays active makes the service routine run again after every acknowledge.

The request reaches the CPU only while the CPU mask bit is clear. The latch keeps running while the request is masked, and software can poll the latch through a read-only flag in a small control/status register. A separate output gives the synchronized level of the dedicated pin alone, for branch-on-pin instructions. The latch is cleared in two ways: by an acknowledge pulse from the CPU, or by writing 1 to the acknowledge bit of the register.

Top module: `eirq_combiner`

## Requirements
- R1: After reset, `ctrl_rdata_o` reads 4'b0001: the trigger mode bit (bit 0) is 1, meaning edge-and-level, the group enable (bit 1) is 0 and the request flag (bit 3) is 0. The CPU mask is set, so `irq_req_o` stays 0 even when the latch is set.
- R2: A falling edge on `irq_pin_ni` sets the request latch. With the mask clear, `irq_req_o` rises after the third rising clock edge following the pin change: two edges for the synchronizer and one for the latch.
- R3: A port pin driven high takes part only when `grp_opt_i` is 1 and the group enable (bit 1) is 1. If either one is 0, port pins have no effect on `irq_req_o` or on the request flag.
- R4: In edge-and-level mode (bit 0 = 1), an acknowledge clears the latch. If the combined line is still active, the latch sets again one cycle later.
- R5: In edge-only mode (bit 0 = 0), the latch sets only when the combined line goes from inactive to active. After an acknowledge it stays clear until the line has gone inactive and then active again. A second wired-OR source that rises while another source holds the line active does not set it.
- R6: `pin_level_o` is 1 when `irq_pin_ni` is high and follows it with a latency of two clock edges. The port pins never affect it.
- R7: While the CPU mask is set, `irq_req_o` is 0 but the request flag (bit 3) still shows the latch. Clearing the mask asserts `irq_req_o` on the next edge when the latch is set.
- R8: The latch is cleared either by a one-cycle pulse on `irq_ack_i` or by a register write with bit 2 = 1. In a write, bits 0 and 1 load the mode and enable. Bit 2 always reads back 0.
- R9: A pulse on `mask_set_i` sets the CPU mask and a pulse on `mask_clr_i` clears it, each taking effect on the next edge. If both are high in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pin_ni | input | 1 | Dedicated interrupt pin, active low, asynchronous |
| port_pins_i | input | NUM_PORT | Port pin interrupt sources, active high, asynchronous |
| grp_opt_i | input | 1 | Fixed option that connects the port group |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 4 | Write data: bit0 trigger mode, bit1 group enable, bit2 acknowledge |
| ctrl_rdata_o | output | 4 | Read data: bit0 mode, bit1 enable, bit2 reads 0, bit3 request flag |
| irq_ack_i | input | 1 | Acknowledge pulse from the CPU; clears the latch |
| mask_set_i | input | 1 | Sets the CPU interrupt mask |
| mask_clr_i | input | 1 | Clears the CPU interrupt mask |
| irq_req_o | output | 1 | Interrupt request to the CPU (latch and not masked) |
| pin_level_o | output | 1 | Synchronized level of the dedicated pin only |

## Verification
A pin change reaches `pin_level_o` after two rising edges and reaches the latch, and so `irq_req_o` and the flag, after three. Acknowledge pulses, register writes and mask pulses act on the next edge. Each directed check therefore samples on the falling edge after the exact edge count: for R2 at edges one, two and three, and for R6 at edges one and two. The table-driven part waits four cycles after each change in the inputs, pulses the acknowledge, and waits three more cycles before sampling. That margin covers the synchronizer and the re-latch in level mode.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int CTRL_W   = 4;
  localparam int BIT_LVL  = 0;
  localparam int BIT_EN   = 1;
  localparam int BIT_ACK  = 2;
  localparam int BIT_FLAG = 3;

  typedef struct packed {
    logic level_mode;
    logic grp_en;
  } eirq_cfg_t;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= {W{RST_VAL}};
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= {W{RST_VAL}};
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              latch_i,
  input  logic              mask_set_i,
  input  logic              mask_clr_i,
  output eirq_cfg_t         cfg_o,
  output logic              sw_ack_o,
  output logic              mask_o,
  output logic [CTRL_W-1:0] rdata_o
);
  eirq_cfg_t cfg_q;
  logic      mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.level_mode <= 1'b1;
      cfg_q.grp_en     <= 1'b0;
    end else if (we_i) begin
      cfg_q.level_mode <= wdata_i[BIT_LVL];
      cfg_q.grp_en     <= wdata_i[BIT_EN];
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mask_q <= 1'b1;
    else if (mask_set_i) mask_q <= 1'b1;
    else if (mask_clr_i) mask_q <= 1'b0;
  end

  assign sw_ack_o = we_i & wdata_i[BIT_ACK];
  assign cfg_o    = cfg_q;
  assign mask_o   = mask_q;

  always_comb begin
    rdata_o           = '0;
    rdata_o[BIT_LVL]  = cfg_q.level_mode;
    rdata_o[BIT_EN]   = cfg_q.grp_en;
    rdata_o[BIT_FLAG] = latch_i;
  end

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_set_i |=> mask_q); // R9
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_clr_i && !mask_set_i) |=> !mask_q); // R9
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
#(
  parameter int NUM_PORT = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pin_sync_i,
  input  logic [NUM_PORT-1:0] port_sync_i,
  input  logic                grp_opt_i,
  input  eirq_cfg_t           cfg_i,
  input  logic                clr_i,
  output logic                latch_o
);
  logic grp_act, act_line, act_q, rise, set_req, latch_q;

  // polarity-normalized combined line: 1 = requesting
  assign grp_act  = grp_opt_i & cfg_i.grp_en & (|port_sync_i);
  assign act_line = ~pin_sync_i | grp_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_line;
  end

  assign rise    = act_line & ~act_q;
  assign set_req = rise | (cfg_i.level_mode & act_line);

  // clear wins; level mode re-sets on the following cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      latch_q <= 1'b0;
    else if (clr_i)   latch_q <= 1'b0;
    else if (set_req) latch_q <= 1'b1;
  end

  assign latch_o = latch_q;

  AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !clr_i) |=> latch_q); // R2
  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.level_mode && act_line && !clr_i) |=> latch_q); // R4
  AST_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.level_mode && !rise && !latch_q) |=> !latch_q); // R5
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !latch_q); // R8
  AST_GRP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(grp_opt_i && cfg_i.grp_en) && pin_sync_i) |-> !act_line); // R3
endmodule

// File: rtl/eirq_combiner.sv
module eirq_combiner
  import eirq_pkg::*;
#(
  parameter int NUM_PORT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                irq_pin_ni,
  input  logic [NUM_PORT-1:0] port_pins_i,
  input  logic                grp_opt_i,
  input  logic                ctrl_we_i,
  input  logic [CTRL_W-1:0]   ctrl_wdata_i,
  output logic [CTRL_W-1:0]   ctrl_rdata_o,
  input  logic                irq_ack_i,
  input  logic                mask_set_i,
  input  logic                mask_clr_i,
  output logic                irq_req_o,
  output logic                pin_level_o
);
  logic                pin_sync;
  logic [NUM_PORT-1:0] port_sync;
  eirq_cfg_t           cfg;
  logic                sw_ack, mask, latch, clr;

  eirq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(irq_pin_ni), .q_o(pin_sync)
  );

  eirq_sync #(.W(NUM_PORT), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_port_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(port_pins_i), .q_o(port_sync)
  );

  eirq_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl_we_i),
    .wdata_i   (ctrl_wdata_i),
    .latch_i   (latch),
    .mask_set_i(mask_set_i),
    .mask_clr_i(mask_clr_i),
    .cfg_o     (cfg),
    .sw_ack_o  (sw_ack),
    .mask_o    (mask),
    .rdata_o   (ctrl_rdata_o)
  );

  assign clr = irq_ack_i | sw_ack;

  eirq_detect #(.NUM_PORT(NUM_PORT)) u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_sync_i (pin_sync),
    .port_sync_i(port_sync),
    .grp_opt_i  (grp_opt_i),
    .cfg_i      (cfg),
    .clr_i      (clr),
    .latch_o    (latch)
  );

  assign irq_req_o   = latch & ~mask;
  assign pin_level_o = pin_sync;

  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_set_i && !irq_ack_i) |=> !irq_req_o); // R7
endmodule

// File: tb/tb_eirq_combiner.sv
module tb_eirq_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pin_n = 1'b1;
  logic [NP-1:0] ports = '0;
  logic          grp_opt = 1'b1;
  logic          we = 1'b0;
  logic [3:0]    wdata = '0;
  logic [3:0]    rdata;
  logic          ack = 1'b0;
  logic          mset = 1'b0;
  logic          mclr = 1'b0;
  logic          req;
  logic          plvl;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eirq_combiner #(.NUM_PORT(NP), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_ni(pin_n), .port_pins_i(ports),
    .grp_opt_i(grp_opt), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .ctrl_rdata_o(rdata), .irq_ack_i(ack), .mask_set_i(mset),
    .mask_clr_i(mclr), .irq_req_o(req), .pin_level_o(plvl)
  );

  // rows: [6] pin_n, [5:2] ports, [1] ack pulse, [0] expected irq_req_o
  localparam logic [6:0] TBL [9] = '{
    7'b1_0000_1_0, 7'b0_0000_0_1, 7'b0_0000_1_1,
    7'b1_0000_1_0, 7'b1_0100_0_1, 7'b1_0100_1_1,
    7'b1_0000_1_0, 7'b0_1001_0_1, 7'b1_0000_1_0
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] d);
    we = 1'b1; wdata = d; step(1); we = 1'b0; wdata = '0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic pulse_mset();
    mset = 1'b1; step(1); mset = 1'b0;
  endtask

  task automatic pulse_mclr();
    mclr = 1'b1; step(1); mclr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 rdata", rdata, 4'b0001);
    chk("R1 req", {3'b0, req}, 4'd0);
    chk("R1 plvl", {3'b0, plvl}, 4'd1);
    pin_n = 1'b0; step(4);
    chk("R1 masked req", {3'b0, req}, 4'd0);
    chk("R1 flag", {3'b0, rdata[3]}, 4'd1);
    pin_n = 1'b1; step(4); pulse_ack(); pulse_mclr(); step(2);
    chk("R1 clean", {3'b0, req}, 4'd0);

    // R2 latency of three edges
    pin_n = 1'b0;
    step(1); chk("R2 e1", {3'b0, req}, 4'd0);
    step(1); chk("R2 e2", {3'b0, req}, 4'd0);
    step(1); chk("R2 e3", {3'b0, req}, 4'd1);
    pin_n = 1'b1; step(4); pulse_ack(); step(1);

    // table: level mode, group enabled, mask clear (R4, R8, R3)
    wr(4'b0011);
    for (int i = 0; i < 9; i++) begin
      pin_n = TBL[i][6];
      ports = TBL[i][5:2];
      step(4);
      if (TBL[i][1]) pulse_ack();
      step(3);
      chk($sformatf("R4 row%0d", i), {3'b0, req}, {3'b0, TBL[i][0]});
    end

    // R5 edge-only mode
    wr(4'b0010);
    pin_n = 1'b0; step(4);
    chk("R5 first edge", {3'b0, rdata[3]}, 4'd1);
    pulse_ack(); step(3);
    chk("R5 no rearm", {3'b0, rdata[3]}, 4'd0);
    step(10);
    chk("R5 held low", {3'b0, rdata[3]}, 4'd0);
    ports = 4'b0010; step(4);
    chk("R5 wired-or no edge", {3'b0, rdata[3]}, 4'd0);
    pin_n = 1'b1; ports = '0; step(4);
    chk("R5 idle", {3'b0, rdata[3]}, 4'd0);
    ports = 4'b0100; step(4);
    chk("R5 rearmed", {3'b0, rdata[3]}, 4'd1);
    ports = '0; step(4); pulse_ack(); step(1);

    // R3 gating of the group
    wr(4'b0001);
    ports = 4'b1000; step(4);
    chk("R3 en off", {2'b0, rdata[3], req}, 4'd0);
    ports = '0; step(3);
    grp_opt = 1'b0; wr(4'b0011);
    ports = 4'b0001; step(4);
    chk("R3 opt off", {2'b0, rdata[3], req}, 4'd0);
    grp_opt = 1'b1; step(2);
    chk("R3 both on", {3'b0, req}, 4'd1);
    ports = '0; step(4); pulse_ack(); step(1);

    // R6 pin level status
    pin_n = 1'b0;
    step(1); chk("R6 e1", {3'b0, plvl}, 4'd1);
    step(1); chk("R6 e2", {3'b0, plvl}, 4'd0);
    pin_n = 1'b1; ports = 4'b1111; step(3);
    chk("R6 ports ignored", {3'b0, plvl}, 4'd1);
    ports = '0; step(4); pulse_ack(); step(1);

    // R7 / R9 masking
    pulse_mset();
    pin_n = 1'b0; step(4);
    chk("R7 masked", {3'b0, req}, 4'd0);
    chk("R7 flag", {3'b0, rdata[3]}, 4'd1);
    pulse_mclr();
    chk("R7 unmask", {3'b0, req}, 4'd1);
    pulse_mset();
    chk("R9 remask", {3'b0, req}, 4'd0);
    mset = 1'b1; mclr = 1'b1; step(1); mset = 1'b0; mclr = 1'b0;
    chk("R9 set wins", {3'b0, req}, 4'd0);
    pulse_mclr();

    // R8 software acknowledge
    pin_n = 1'b1; step(4);
    chk("R8 held", {3'b0, rdata[3]}, 4'd1);
    wr(4'b0111);
    chk("R8 sw ack", rdata, 4'b0011);
    chk("R8 req off", {3'b0, req}, 4'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule